// File: doc/BRIEF.md
# Receive address filter

This block sits in an Ethernet receive path and decides, for each incoming frame, whether the frame is kept or dropped. It compares the first six bytes of the frame, the destination address, with a station address held in six byte-wide registers. A two-bit accept mode selects one of four policies: drop everything, keep only frames addressed to the station, keep those plus broadcast frames, or keep everything.

The receive side signals the start of a frame with a one-cycle strobe. It then presents bytes with a valid qualifier and a flag on the final byte of the frame. Once the sixth destination byte has been taken, the block raises a one-cycle decision strobe with an accept bit. A frame that ends before six bytes are seen is rejected at its last byte. The mode and the station address are copied into a working set at each frame start, so software may reprogram them at any time without disturbing a frame in progress.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0, and bytes presented before the first frame-start strobe produce no decision.
- R2: Station byte register index 0 is compared with the first destination byte on the wire and index 5 with the sixth; a write to index 6 or 7 changes nothing.
- R3: Mode 0 (off) rejects every frame, including station-addressed and broadcast frames.
- R4: Mode 1 (physical) accepts a frame only when all six destination bytes equal the station address; a difference in any single byte, first or last, rejects it, and broadcast is rejected.
- R5: Mode 2 (physical plus broadcast) accepts a station-addressed frame or a frame whose destination is 48 one bits (FF in every byte), and rejects anything else.
- R6: Mode 3 (promiscuous) accepts every frame that carries six destination bytes.
- R7: `dec_valid` is high for exactly one cycle per frame, in the cycle right after the clock edge that takes the sixth destination byte; later bytes and the last-byte flag after it add no further strobe.
- R8: A frame whose last-byte flag arrives before six bytes gives a reject decision (`dec_valid`=1, `dec_accept`=0) in the cycle after that last byte, in every mode.
- R9: A frame-start strobe clears the byte count and match state even mid-frame, so no decision is given for the abandoned frame; a byte valid in the same cycle as the strobe is the first byte of the new frame.
- R10: The mode and station address in use are those present at the frame-start strobe; changes during a frame, and a register write in the same cycle as the strobe, act only from the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Station byte register write enable |
| cfg_idx | input | 3 | Station byte register index (0 to 5 used) |
| cfg_wdata | input | 8 | Station byte register write data |
| cfg_mode | input | 2 | Accept mode: 0 off, 1 physical, 2 physical plus broadcast, 3 all |
| frm_start | input | 1 | One-cycle frame-start strobe |
| byte_valid | input | 1 | Receive byte is valid this cycle |
| byte_data | input | 8 | Receive byte, destination first |
| byte_last | input | 1 | Marks the final byte of the frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision: 1 keep, 0 drop; meaningful with dec_valid |

## Verification
The two functions that can meet in one cycle are the frame-start clear and the byte comparison: a new strobe can arrive together with a valid byte, including the byte that would have been the sixth of the abandoned frame. The bench provokes this by restarting after five station bytes with the strobe and the first byte of a new frame in the same cycle, and judges it by exactly one accepting strobe arriving only after the new frame's sixth byte. A register write coinciding with the strobe is also driven, and judged by the current frame using the old value and the next frame using the new one.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_OFF        = 2'd0,
        ACC_PHYS       = 2'd1,
        ACC_PHYS_BCAST = 2'd2,
        ACC_ALL        = 2'd3
    } acc_mode_e;

    // Request from the byte tracker to the decision stage.
    typedef struct packed {
        logic      fire;   // a decision is due this cycle
        logic      full;   // all destination bytes have been seen
        logic      phys;   // destination equals station address so far
        logic      bcast;  // destination is all ones so far
        acc_mode_e mode;   // mode in force for this frame
    } verdict_req_t;

    function automatic logic judge(acc_mode_e m, logic full, logic phys, logic bcast);
        logic r;
        if (!full) begin
            r = 1'b0;
        end else begin
            case (m)
                ACC_OFF:        r = 1'b0;
                ACC_PHYS:       r = phys;
                ACC_PHYS_BCAST: r = phys | bcast;
                default:        r = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_addr_filter_regs.sv
module rx_addr_filter_regs
    import rx_addr_filter_pkg::*;
#(
    parameter int unsigned N_BYTES = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [BYTE_W-1:0]               wr_data,
    input  acc_mode_e                       mode_in,
    input  logic                            frm_start,
    output logic [N_BYTES-1:0][BYTE_W-1:0]  cur_sta,
    output acc_mode_e                       cur_mode
);

    logic [N_BYTES-1:0][BYTE_W-1:0] cfg_sta;
    logic [N_BYTES-1:0][BYTE_W-1:0] act_sta;
    acc_mode_e                      act_mode;

    genvar gi;
    generate
        for (gi = 0; gi < N_BYTES; gi++) begin : g_sta
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_sta[gi] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                    cfg_sta[gi] <= wr_data;
                end
            end
        end
    endgenerate

    // Working copy captured at frame start; held for the whole frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_sta  <= '0;
            act_mode <= ACC_OFF;
        end else if (frm_start) begin
            act_sta  <= cfg_sta;
            act_mode <= mode_in;
        end
    end

    // A byte arriving with the start strobe already uses the new settings.
    always_comb begin
        cur_sta  = frm_start ? cfg_sta : act_sta;
        cur_mode = frm_start ? mode_in : act_mode;
    end

    assert_hold_mid_frame_R10: assert property (@(posedge clk) disable iff (rst)
        !frm_start |=> ($stable(act_mode) && $stable(act_sta)));

endmodule

// File: rtl/rx_addr_filter_track.sv
module rx_addr_filter_track
    import rx_addr_filter_pkg::*;
#(
    parameter int unsigned N_BYTES = 6,
    parameter int unsigned CNT_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frm_start,
    input  logic                            byte_valid,
    input  logic [BYTE_W-1:0]               byte_data,
    input  logic                            byte_last,
    input  logic [N_BYTES-1:0][BYTE_W-1:0]  cur_sta,
    input  acc_mode_e                       cur_mode,
    output verdict_req_t                    req
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_BYTES - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             phys_ok;
    logic             bc_ok;

    logic             b_busy;
    logic [CNT_W-1:0] b_cnt;
    logic             b_phys;
    logic             b_bc;
    logic             take;
    logic             at_end;
    logic             n_phys;
    logic             n_bc;
    logic [BYTE_W-1:0] sel_byte;

    // State as seen this cycle, after a possible restart.
    always_comb begin
        b_busy   = frm_start | busy;
        b_cnt    = frm_start ? '0 : cnt;
        b_phys   = frm_start | phys_ok;
        b_bc     = frm_start | bc_ok;
        take     = byte_valid & b_busy;
        at_end   = (b_cnt == LAST_IDX);
        sel_byte = cur_sta[b_cnt];
        n_phys   = b_phys & (byte_data == sel_byte);
        n_bc     = b_bc & (byte_data == {BYTE_W{1'b1}});
    end

    always_comb begin
        req.fire  = take & (at_end | byte_last);
        req.full  = take & at_end;
        req.phys  = n_phys;
        req.bcast = n_bc;
        req.mode  = cur_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            phys_ok <= 1'b1;
            bc_ok   <= 1'b1;
        end else begin
            busy    <= b_busy;
            cnt     <= b_cnt;
            phys_ok <= b_phys;
            bc_ok   <= b_bc;
            if (take) begin
                if (at_end || byte_last) begin
                    busy <= 1'b0;
                end else begin
                    cnt     <= b_cnt + 1'b1;
                    phys_ok <= n_phys;
                    bc_ok   <= n_bc;
                end
            end
        end
    end

    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_IDX);

    assert_fire_needs_byte_R7: assert property (@(posedge clk) disable iff (rst)
        req.fire |-> byte_valid);

    assert_idle_after_decision_R7: assert property (@(posedge clk) disable iff (rst)
        req.fire && !frm_start |=> !busy || frm_start);

endmodule

// File: rtl/rx_addr_filter_decide.sv
module rx_addr_filter_decide
    import rx_addr_filter_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  verdict_req_t req,
    output logic         dec_valid,
    output logic         dec_accept
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= req.fire;
            dec_accept <= req.fire & judge(req.mode, req.full, req.phys, req.bcast);
        end
    end

    assert_off_never_accepts_R3: assert property (@(posedge clk) disable iff (rst)
        (req.fire && req.mode == ACC_OFF) |=> !dec_accept);

    assert_promisc_accepts_R6: assert property (@(posedge clk) disable iff (rst)
        (req.fire && req.full && req.mode == ACC_ALL) |=> dec_accept);

    assert_short_rejects_R8: assert property (@(posedge clk) disable iff (rst)
        (req.fire && !req.full) |=> (dec_valid && !dec_accept));

    assert_accept_has_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_valid);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int unsigned N_BYTES = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        cfg_mode,
    input  logic              frm_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam int unsigned CNT_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

    logic [N_BYTES-1:0][BYTE_W-1:0] cur_sta;
    acc_mode_e                      cur_mode;
    verdict_req_t                   req;

    rx_addr_filter_regs #(
        .N_BYTES (N_BYTES),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_wdata),
        .mode_in   (acc_mode_e'(cfg_mode)),
        .frm_start (frm_start),
        .cur_sta   (cur_sta),
        .cur_mode  (cur_mode)
    );

    rx_addr_filter_track #(
        .N_BYTES (N_BYTES),
        .CNT_W   (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .frm_start  (frm_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .cur_sta    (cur_sta),
        .cur_mode   (cur_mode),
        .req        (req)
    );

    rx_addr_filter_decide u_decide (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

    typedef struct packed {
        logic [1:0]  mode;
        logic [47:0] dst;
        logic [3:0]  len;
        logic        exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 48'h02_11_22_33_44_55, 4'd8, 1'b1},
        '{2'd1, 48'h02_11_22_33_44_54, 4'd8, 1'b0},
        '{2'd1, 48'h03_11_22_33_44_55, 4'd8, 1'b0},
        '{2'd1, 48'hFF_FF_FF_FF_FF_FF, 4'd8, 1'b0},
        '{2'd2, 48'hFF_FF_FF_FF_FF_FF, 4'd8, 1'b1},
        '{2'd2, 48'h02_11_22_33_44_55, 4'd7, 1'b1},
        '{2'd2, 48'hFF_FF_FF_FF_FF_FE, 4'd8, 1'b0},
        '{2'd0, 48'h02_11_22_33_44_55, 4'd8, 1'b0},
        '{2'd0, 48'hFF_FF_FF_FF_FF_FF, 4'd8, 1'b0},
        '{2'd3, 48'h12_34_56_78_9A_BC, 4'd9, 1'b1},
        '{2'd3, 48'h02_11_22_33_44_55, 4'd3, 1'b0},
        '{2'd1, 48'h02_11_22_33_44_55, 4'd6, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] cfg_mode = '0;
    logic       frm_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_last = 1'b0;
    logic       dec_valid;
    logic       dec_accept;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic last_acc = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_mode   (cfg_mode),
        .frm_start  (frm_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    always @(negedge clk) begin
        if (dec_valid) begin
            pulses   = pulses + 1;
            last_acc = dec_accept;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [47:0] d, input int i);
        return d[47-8*i -: 8];
    endfunction

    // All tasks enter and leave at a falling edge.
    task automatic write_reg(input logic [2:0] idx, input logic [7:0] val);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_frame(input logic [1:0] m);
        cfg_mode = m; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, input logic last);
        byte_valid = 1'b1; byte_data = d; byte_last = last;
        @(negedge clk);
        byte_valid = 1'b0; byte_last = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] m, input logic [47:0] d, input int len);
        start_frame(m);
        for (int i = 0; i < len; i++) begin
            put_byte((i < 6) ? byte_of(d, i) : 8'(8'h5A + i), i == len - 1);
        end
    endtask

    task automatic frame_result(input string tag, input int p0, input logic exp);
        #2;
        check(tag, "strobe count", 32'(pulses - p0), 32'd1);
        check(tag, "accept", {31'd0, last_acc}, {31'd0, exp});
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int p0;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "dec_valid after reset", {31'd0, dec_valid}, 32'd0);
        check("R1", "dec_accept after reset", {31'd0, dec_accept}, 32'd0);

        for (int i = 0; i < 6; i++) write_reg(3'(i), byte_of(STA, i));

        // R1: bytes with no frame start yield nothing
        p0 = pulses;
        cfg_mode = 2'd3;
        for (int i = 0; i < 8; i++) put_byte(byte_of(STA, i % 6), i == 7);
        @(negedge clk); #2;
        check("R1", "strobes without frame start", 32'(pulses - p0), 32'd0);
        @(negedge clk);

        // Table walk over modes and addresses (R3, R4, R5, R6, R8)
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].len < 6)       tag = "R8";
            else if (VECS[v].mode == 0) tag = "R3";
            else if (VECS[v].mode == 1) tag = "R4";
            else if (VECS[v].mode == 2) tag = "R5";
            else                        tag = "R6";
            p0 = pulses;
            send_frame(VECS[v].mode, VECS[v].dst, int'(VECS[v].len));
            frame_result(tag, p0, VECS[v].exp);
        end

        // R7: strobe exactly after the sixth byte, single per frame
        p0 = pulses;
        start_frame(2'd1);
        for (int i = 0; i < 10; i++) begin
            put_byte((i < 6) ? byte_of(STA, i) : 8'hC3, i == 9);
            #1;
            check("R7", $sformatf("dec_valid after byte %0d", i),
                  {31'd0, dec_valid}, {31'd0, (i == 5)});
        end
        frame_result("R7", p0, 1'b1);

        // R8: one-byte frame in promiscuous mode
        p0 = pulses;
        send_frame(2'd3, STA, 1);
        frame_result("R8", p0, 1'b0);

        // R2: index 0 is the first byte on the wire; index 6 ignored
        write_reg(3'd0, 8'h77);
        p0 = pulses;
        send_frame(2'd1, 48'h77_11_22_33_44_55, 6);
        frame_result("R2", p0, 1'b1);
        write_reg(3'd0, 8'h02);
        write_reg(3'd6, 8'h00);
        write_reg(3'd7, 8'hFF);
        p0 = pulses;
        send_frame(2'd1, STA, 6);
        frame_result("R2", p0, 1'b1);

        // R9: restart with a byte in the same cycle as the strobe
        p0 = pulses;
        start_frame(2'd1);
        for (int i = 0; i < 5; i++) put_byte(byte_of(STA, i), 1'b0);
        cfg_mode = 2'd1; frm_start = 1'b1;
        put_byte(byte_of(STA, 0), 1'b0);
        frm_start = 1'b0;
        #1;
        check("R9", "no strobe for abandoned frame", 32'(pulses - p0), 32'd0);
        for (int i = 1; i < 6; i++) put_byte(byte_of(STA, i), i == 5);
        frame_result("R9", p0, 1'b1);

        // R10: mid-frame mode change and address write do not apply yet
        p0 = pulses;
        start_frame(2'd1);
        put_byte(byte_of(STA, 0), 1'b0);
        put_byte(byte_of(STA, 1), 1'b0);
        cfg_mode = 2'd0;
        write_reg(3'd5, 8'h99);
        for (int i = 2; i < 6; i++) put_byte(byte_of(STA, i), i == 5);
        frame_result("R10", p0, 1'b1);
        p0 = pulses;
        send_frame(2'd1, 48'h02_11_22_33_44_99, 6);
        frame_result("R10", p0, 1'b1);
        p0 = pulses;
        send_frame(2'd1, STA, 6);
        frame_result("R10", p0, 1'b0);
        write_reg(3'd5, 8'h55);

        // R10: write coinciding with the strobe applies from the next frame
        p0 = pulses;
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_wdata = 8'h66;
        cfg_mode = 2'd1; frm_start = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; frm_start = 1'b0;
        for (int i = 0; i < 6; i++) put_byte(byte_of(STA, i), i == 5);
        frame_result("R10", p0, 1'b1);
        p0 = pulses;
        send_frame(2'd1, STA, 6);
        frame_result("R10", p0, 1'b0);
        write_reg(3'd1, 8'h11);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule